// File: doc/BRIEF.md
# Waveform Timer Channel

This block is one timer channel that generates waveforms. A 16-bit up-counter advances on ticks from a selectable source. That source is the system clock divided by a power of two from 2 to 1024, or the rising edges of a slower external clock after they are synchronised. The counter stays still after configuration. It starts only when a trigger arrives, either a software command or a rising edge on an external trigger pin. A trigger always restarts the count from zero.

Three compare registers act on two output levels, A and B:
- The first compare register drives A.
- The second compare register drives B.
- The period register drives both A and B. Its match can also reload the counter to zero, which sets the waveform period.

Each match applies a 2-bit action: none, set, clear or toggle. Each output has its own enable. Matches and counter wrap-around latch sticky status bits. A read of the status register clears them. One level interrupt reports any status bit whose enable is set.

Control is a two-state machine:
- `ST_IDLE` moves to `ST_RUN` on transition `T_START`, which is a trigger.
- `ST_RUN` loops on itself on `T_RESTART`, which is another trigger.
- `ST_RUN` returns to `ST_IDLE` on `T_HALT`, which is any write to the control register.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the counter reads 0, both outputs and the interrupt are low, and the channel is idle. A write to the control register (address 0) makes the channel idle and the count holds its value. While idle the count does not change until a trigger occurs.
- R2: A trigger does three things on the next clock edge: it zeroes the counter, clears both output levels and starts the channel. There are two trigger sources. One is a write to address 7 with data bit 0 set. The other is a rising edge on `ext_trig_i`, seen through two synchroniser flops, and it counts only when control bit 13 is set. A trigger in the same cycle as a control write is ignored.
- R3: Control bits [3:0] select the tick source. A value s from 0 to 9 gives one tick every 2^(s+1) system cycles, with the divider restarted by a trigger. The value 10 gives one tick per rising edge of `ext_clk_i`, seen through two synchroniser flops. Values 11 to 15 give no ticks.
- R4: On a tick where the count equals the period register (address 3) and control bit 12 is set, the counter reloads to 0. On other ticks it increments.
- R5: On a tick at count 0xFFFF without an R4 reload, the counter wraps to 0 and sets overflow status bit 0.
- R6: Each action code is 0 none, 1 set, 2 clear or 3 toggle. Control bits [5:4] act on A when the count matches address 1. Bits [7:6] act on B when the count matches address 2. Bits [9:8] act on A and bits [11:10] act on B when the count matches address 3.
- R7: When more than one action lands on an output in the same cycle, a trigger (which clears it) beats a period-register action other than none, and that beats the own compare action.
- R8: Output A follows its level only while control bit 14 is set, and output B only while bit 15 is set. Otherwise each is held low.
- R9: Status (address 5) sets bit 2, 3 or 4 on a tick whose count matches address 1, 2 or 3. A read with `bus_rd` clears the status, except for events that land in that same cycle.
- R10: `irq` is high exactly while some status bit is set together with the same bit of the enable register (address 6). Bit 4 is the period-compare event.
- R11: Addresses 0 to 6 read back their contents, and address 4 gives the live count. A write to address 4 has no effect.
- R12: An external trigger edge while control bit 13 is clear neither starts nor restarts the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count clock, slower than clk |
| ext_trig_i | input | 1 | External trigger, rising edge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status at address 5) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives stimulus that lands a trigger in the same cycle as period matches, and sets the first compare and the period register to the same value with opposite actions. A design that ordered priority wrongly would show toggling where a steady level is expected. It lets the count run through the full 16-bit range so that overflow status and the interrupt are raised only by wrap-around; an off-by-one wrap would miss them. It pulses the external trigger while it is disabled, writes the count register and clears status by a read. A design that leaked any of these would move the count, keep the interrupt high, or let a stray edge restart the channel. Divided and external tick sources are checked by counting output toggles across exact window lengths, which catches a divider off by one stage.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STS  = 3'd5;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd7;

    localparam int CTRL_W  = 16;
    localparam int SEL_W   = 4;
    localparam int C_ACT_A = 4;
    localparam int C_ACT_B = 6;
    localparam int C_PER_A = 8;
    localparam int C_PER_B = 10;
    localparam int C_RELOAD = 12;
    localparam int C_XTRIG = 13;
    localparam int C_EN_A  = 14;
    localparam int C_EN_B  = 15;

    localparam int STS_W   = 5;
    localparam int S_OVF   = 0;
    localparam int S_CMPA  = 2;
    localparam int S_CMPB  = 3;
    localparam int S_PER   = 4;

    function automatic logic apply_act(act_e a, logic lvl);
        logic r;
        unique case (a)
            ACT_NONE: r = lvl;
            ACT_SET:  r = 1'b1;
            ACT_CLR:  r = 1'b0;
            ACT_TGL:  r = ~lvl;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wt_sync_edge.sv
module wt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
    parameter int MAX_DIV = 1024,
    parameter int SEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_rise,
    output logic             tick
);
    localparam int PS_W    = $clog2(MAX_DIV);
    localparam int EXT_SEL = PS_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ps_q <= '0;
        else if (restart) ps_q <= '0;
        else              ps_q <= ps_q + 1'b1;
    end

    for (genvar g = 0; g < PS_W; g++) begin : g_mask
        assign mask[g] = (sel >= SEL_W'(g));
    end

    always_comb begin
        if (sel < SEL_W'(EXT_SEL))       tick = &(ps_q | ~mask);
        else if (sel == SEL_W'(EXT_SEL)) tick = ext_rise;
        else                             tick = 1'b0;
    end
endmodule

// File: rtl/wt_out_level.sv
module wt_out_level
    import wt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    input  logic per_hit,
    input  act_e per_act,
    input  logic own_hit,
    input  act_e own_act,
    output logic level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              level <= 1'b0;
        else if (clear)                          level <= 1'b0;
        else if (adv && per_hit && per_act != ACT_NONE)
                                                 level <= apply_act(per_act, level);
        else if (adv && own_hit)                 level <= apply_act(own_act, level);
    end
endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
    import wt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MAX_DIV     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_i,
    input  logic              ext_trig_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq
);
    localparam int NCH = 2;

    state_e             state_q, state_d;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [CNT_W-1:0]   cmpa_q, cmpb_q, per_q, cnt_q;
    logic [STS_W-1:0]   ien_q, sts_q, sts_set;

    logic wr_ctrl, sw_trig, rd_sts, start, run_en;
    logic xclk_rise, xtrig_rise, raw_tick, adv;
    logic hit_a, hit_b, hit_per, reload, ovf_hit;
    logic [NCH-1:0] own_hit_v, lvl_v;
    act_e own_act_v [NCH];
    act_e per_act_v [NCH];

    wt_sync_edge #(.STAGES(SYNC_STAGES)) u_xclk (
        .clk(clk), .rst_n(rst_n), .din(ext_clk_i), .rise(xclk_rise));
    wt_sync_edge #(.STAGES(SYNC_STAGES)) u_xtrig (
        .clk(clk), .rst_n(rst_n), .din(ext_trig_i), .rise(xtrig_rise));

    assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
    assign sw_trig = bus_wr && bus_addr == A_CMD && bus_wdata[0];
    assign rd_sts  = bus_rd && bus_addr == A_STS;
    assign start   = (sw_trig | (ctrl_q[C_XTRIG] & xtrig_rise)) & ~wr_ctrl;

    wt_prescaler #(.MAX_DIV(MAX_DIV), .SEL_W(SEL_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .sel(ctrl_q[SEL_W-1:0]), .ext_rise(xclk_rise), .tick(raw_tick));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_START, T_RESTART, T_HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_RUN;
            ST_RUN:  if (wr_ctrl) state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: run_en = 1'b0;
            ST_RUN:  run_en = 1'b1;
        endcase
    end

    assign adv     = run_en & raw_tick & ~start & ~wr_ctrl;
    assign hit_a   = cnt_q == cmpa_q;
    assign hit_b   = cnt_q == cmpb_q;
    assign hit_per = cnt_q == per_q;
    assign reload  = hit_per & ctrl_q[C_RELOAD];
    assign ovf_hit = (&cnt_q) & ~reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= '0;
        else if (adv)   cnt_q <= reload ? '0 : cnt_q + 1'b1;
    end

    always_comb begin
        sts_set = '0;
        if (adv) begin
            sts_set[S_OVF]  = ovf_hit;
            sts_set[S_CMPA] = hit_a;
            sts_set[S_CMPB] = hit_b;
            sts_set[S_PER]  = hit_per;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (rd_sts ? '0 : sts_q) | sts_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
            per_q  <= '0;
            ien_q  <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL:  ctrl_q <= bus_wdata[CTRL_W-1:0];
                A_CMPA:  cmpa_q <= bus_wdata;
                A_CMPB:  cmpb_q <= bus_wdata;
                A_PER:   per_q  <= bus_wdata;
                A_IEN:   ien_q  <= bus_wdata[STS_W-1:0];
                default: ;
            endcase
        end
    end

    assign own_hit_v    = {hit_b, hit_a};
    assign own_act_v[0] = act_e'(ctrl_q[C_ACT_A +: 2]);
    assign own_act_v[1] = act_e'(ctrl_q[C_ACT_B +: 2]);
    assign per_act_v[0] = act_e'(ctrl_q[C_PER_A +: 2]);
    assign per_act_v[1] = act_e'(ctrl_q[C_PER_B +: 2]);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
        wt_out_level u_lvl (
            .clk(clk), .rst_n(rst_n), .clear(start), .adv(adv),
            .per_hit(hit_per), .per_act(per_act_v[ch]),
            .own_hit(own_hit_v[ch]), .own_act(own_act_v[ch]),
            .level(lvl_v[ch]));
    end

    assign wave_a = lvl_v[0] & ctrl_q[C_EN_A];
    assign wave_b = lvl_v[1] & ctrl_q[C_EN_B];
    assign irq    = |(sts_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = CNT_W'(ctrl_q);
            A_CMPA:  bus_rdata = cmpa_q;
            A_CMPB:  bus_rdata = cmpb_q;
            A_PER:   bus_rdata = per_q;
            A_CNT:   bus_rdata = cnt_q;
            A_STS:   bus_rdata = CNT_W'(sts_q);
            A_IEN:   bus_rdata = CNT_W'(ien_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             start,
    input logic             wr_ctrl,
    input logic             raw_tick,
    input logic             rd_sts,
    input logic             reload_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic [4:0]       sts,
    input logic             irq,
    input logic [1:0]       lvl
);
    logic step;
    assign step = run_en && raw_tick && !start && !wr_ctrl;

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !start) |=> $stable(cnt));

    assert_halt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !run_en);

    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == '0 && lvl == 2'b00 && run_en));

    assert_period_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && reload_en && cnt == per) |=> cnt == '0);

    assert_wrap_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&cnt) && !(reload_en && cnt == per)) |=> (cnt == '0 && sts[0]));

    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !step) |=> (sts == '0 && !irq));
endmodule

bind wave_timer_chan wt_checker #(.CNT_W(CNT_W)) u_wt_checker (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
    .wr_ctrl(wr_ctrl), .raw_tick(raw_tick), .rd_sts(rd_sts),
    .reload_en(ctrl_q[12]), .cnt(cnt_q), .per(per_q), .sts(sts_q),
    .irq(irq), .lvl(lvl_v));

// File: tb/wave_timer_chan_bench.sv
`timescale 1ns/1ps
module wave_timer_chan_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_clk = 1'b0, ext_trig = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd4;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic wave_a, wave_b, irq;

    int n_chk = 0, n_err = 0;
    int ec_cnt = 0;
    bit ec_on = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wave_timer_chan u_wave_timer_chan (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .ext_trig_i(ext_trig),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wave_a(wave_a), .wave_b(wave_b), .irq(irq));

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctrl, m_ra, m_rb, m_rc, m_cnt;
    logic [4:0]  m_ien, m_sts;
    bit m_run, m_la, m_lb;
    int m_ps;
    bit [2:0] m_ec, m_tg;

    function automatic bit act(logic [1:0] c, bit l);
        case (c)
            2'd1: return 1'b1;
            2'd2: return 1'b0;
            2'd3: return ~l;
            default: return l;
        endcase
    endfunction

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_ra;
            3'd2: return m_rb;
            3'd3: return m_rc;
            3'd4: return m_cnt;
            3'd5: return {11'd0, m_sts};
            3'd6: return {11'd0, m_ien};
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit ec_r, tg_r, wc, sw, st, tk, adv, ha, hb, hc, rl;
        int sel;
        logic [4:0] set;
        if (!rst_n) begin
            m_ctrl = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_cnt = 0;
            m_ien = 0; m_sts = 0; m_run = 0; m_la = 0; m_lb = 0;
            m_ps = 0; m_ec = 0; m_tg = 0;
        end else begin
            ec_r = m_ec[1] & ~m_ec[2];
            tg_r = m_tg[1] & ~m_tg[2];
            m_ec = {m_ec[1:0], ext_clk};
            m_tg = {m_tg[1:0], ext_trig};
            sel = int'(m_ctrl[3:0]);
            wc = bus_wr && bus_addr == 3'd0;
            sw = bus_wr && bus_addr == 3'd7 && bus_wdata[0];
            st = (sw || (m_ctrl[13] && tg_r)) && !wc;
            if (sel <= 9) tk = (m_ps % (1 << (sel + 1))) == ((1 << (sel + 1)) - 1);
            else          tk = (sel == 10) && ec_r;
            adv = m_run && tk && !st && !wc;
            set = '0;
            if (st) begin
                m_cnt = 0; m_la = 0; m_lb = 0;
            end else if (adv) begin
                ha = m_cnt == m_ra; hb = m_cnt == m_rb; hc = m_cnt == m_rc;
                rl = hc && m_ctrl[12];
                set[2] = ha; set[3] = hb; set[4] = hc;
                set[0] = (m_cnt == 16'hFFFF) && !rl;
                if (hc && m_ctrl[9:8] != 0)  m_la = act(m_ctrl[9:8], m_la);
                else if (ha)                 m_la = act(m_ctrl[5:4], m_la);
                if (hc && m_ctrl[11:10] != 0) m_lb = act(m_ctrl[11:10], m_lb);
                else if (hb)                  m_lb = act(m_ctrl[7:6], m_lb);
                m_cnt = rl ? 16'd0 : m_cnt + 16'd1;
            end
            m_ps = st ? 0 : (m_ps + 1) % 1024;
            if (bus_rd && bus_addr == 3'd5) m_sts = 0;
            m_sts = m_sts | set;
            if (wc) m_run = 0;
            else if (st) m_run = 1;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_ctrl = bus_wdata;
                    3'd1: m_ra = bus_wdata;
                    3'd2: m_rb = bus_wdata;
                    3'd3: m_rc = bus_wdata;
                    3'd6: m_ien = bus_wdata[4:0];
                    default: ;
                endcase
            end
        end
    end

    // every-cycle comparison, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && !done) begin
                check(wave_a == (m_ctrl[14] & m_la), "R6/R8 wave_a vs model", wave_a, m_ctrl[14] & m_la);
                check(wave_b == (m_ctrl[15] & m_lb), "R6/R8 wave_b vs model", wave_b, m_ctrl[15] & m_lb);
                check(irq == |(m_sts & m_ien), "R10 irq vs model", irq, |(m_sts & m_ien));
                check(bus_rdata == m_read(bus_addr), "R11 readback vs model", bus_rdata, m_read(bus_addr));
            end
        end
    end

    // external clock source: toggles every 7 system cycles while enabled
    initial begin
        forever begin
            @(negedge clk);
            if (ec_on) begin
                ec_cnt++;
                if (ec_cnt == 7) begin ext_clk = ~ext_clk; ec_cnt = 0; end
            end
        end
    end

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_addr = 3'd4; bus_wdata = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(logic [2:0] a, output logic [15:0] v);
        @(negedge clk); bus_addr = a; #1; v = bus_rdata;
        @(negedge clk); bus_addr = 3'd4;
    endtask

    task automatic pulse_trig();
        @(negedge clk); ext_trig = 1;
        idle(3); ext_trig = 0;
    endtask

    task automatic count_toggles(int n, output int ta);
        bit pa;
        ta = 0; pa = wave_a;
        repeat (n) begin @(negedge clk); if (wave_a != pa) ta++; pa = wave_a; end
    endtask

    initial begin
        #(4 * 195000);
        check(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v, x;
        int t, hi_a, hi_b;
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        check(wave_a == 0 && wave_b == 0, "R1 outputs low after reset", wave_a | wave_b, 0);
        check(irq == 0, "R1 irq low after reset", irq, 0);
        check(bus_rdata == 0, "R1 count zero after reset", bus_rdata, 0);

        // R4/R6: period 6 counts, toggle A on period match, div2
        wr(3'd1, 16'd200); wr(3'd2, 16'd200); wr(3'd3, 16'd5);
        wr(3'd6, 16'h0004);
        wr(3'd0, 16'h0000 | (3 << 8) | (1 << 12) | (1 << 14));
        idle(20);
        check(bus_rdata == 0, "R1 idle before trigger", bus_rdata, 0);
        wr(3'd7, 16'd1);
        idle(20);
        count_toggles(48, t);
        check(t == 4, "R4/R6 toggle count div2 period6", t, 4);
        // halt, mask check, read clear
        wr(3'd0, 16'h0000 | (3 << 8) | (1 << 12) | (1 << 14));
        idle(2);
        check(irq == 0, "R10 masked status keeps irq low", irq, 0);
        peek(3'd5, v);
        check(v[4] == 1, "R9 period status latched", v[4], 1);
        wr(3'd6, 16'h0010);
        check(irq == 1, "R10 enabled bit4 raises irq", irq, 1);
        @(negedge clk); bus_addr = 3'd5; bus_rd = 1;
        @(negedge clk); bus_rd = 0; bus_addr = 3'd4;
        check(irq == 0, "R9 read clears status", irq, 0);

        // R6: RA/RB set, RC clears both, div4
        wr(3'd1, 16'd2); wr(3'd2, 16'd3); wr(3'd3, 16'd6);
        wr(3'd0, 16'd1 | (1 << 4) | (1 << 6) | (2 << 8) | (2 << 10) | (1 << 12) | (3 << 14));
        wr(3'd7, 16'd1);
        idle(40);
        hi_a = 0; hi_b = 0;
        repeat (56) begin @(negedge clk); hi_a += wave_a; hi_b += wave_b; end
        check(hi_a == 32, "R6 A high cycles", hi_a, 32);
        check(hi_b == 24, "R6 B high cycles", hi_b, 24);
        // R8: disable B
        wr(3'd0, 16'd1 | (1 << 4) | (1 << 6) | (2 << 8) | (2 << 10) | (1 << 12) | (1 << 14));
        wr(3'd7, 16'd1);
        hi_b = 0;
        repeat (56) begin @(negedge clk); hi_b += wave_b; end
        check(hi_b == 0, "R8 disabled B held low", hi_b, 0);

        // R7 priority: RA toggle and RC set on same count
        wr(3'd1, 16'd4); wr(3'd3, 16'd4);
        wr(3'd0, 16'd0 | (3 << 4) | (1 << 8) | (1 << 12) | (1 << 14));
        wr(3'd7, 16'd1);
        idle(20);
        count_toggles(40, t);
        check(t == 0 && wave_a == 1, "R7 period action beats own action", wave_a, 1);
        wr(3'd7, 16'd1);
        check(wave_a == 0, "R7/R2 trigger clears level", wave_a, 0);
        repeat (12) begin idle(3); wr(3'd7, 16'd1); end

        // R3: div16, period 4 counts -> toggle every 64 cycles
        wr(3'd1, 16'd300); wr(3'd3, 16'd3);
        wr(3'd0, 16'd3 | (3 << 8) | (1 << 12) | (1 << 14));
        wr(3'd7, 16'd1);
        idle(20);
        count_toggles(128, t);
        check(t == 2, "R3 div16 toggle count", t, 2);
        // R3: external clock, tick every 14 cycles
        ec_on = 1;
        wr(3'd0, 16'd10 | (3 << 8) | (1 << 12) | (1 << 14));
        wr(3'd7, 16'd1);
        idle(60);
        count_toggles(224, t);
        check(t == 4, "R3 external clock toggle count", t, 4);
        ec_on = 0;
        // R3: reserved select gives no ticks
        wr(3'd0, 16'd12 | (1 << 14));
        wr(3'd7, 16'd1);
        idle(40);
        check(bus_rdata == 0, "R3 reserved select holds count", bus_rdata, 0);

        // build a large count, then halt
        wr(3'd0, 16'd0);
        wr(3'd7, 16'd1);
        idle(100);
        wr(3'd0, 16'd0);
        peek(3'd4, x);
        // R11: count not writable
        wr(3'd4, 16'h1234);
        peek(3'd4, v);
        check(v == x, "R11 count write ignored", v, x);
        // R12: disabled external trigger ignored
        pulse_trig();
        idle(10);
        peek(3'd4, v);
        check(v == x, "R12 disabled ext trigger ignored", v, x);
        // R2: enabled external trigger starts
        wr(3'd0, 16'd0 | (1 << 13));
        pulse_trig();
        idle(10);
        peek(3'd4, v);
        check(v < x && v != 0, "R2 ext trigger restarts count", v, 1);

        // R5: full wrap
        wr(3'd3, 16'd3);
        wr(3'd6, 16'h0001);
        wr(3'd0, 16'd0);
        wr(3'd7, 16'd1);
        idle(131072 + 20);
        check(irq == 1, "R5 overflow raises irq", irq, 1);
        peek(3'd5, v);
        check(v[0] == 1, "R5 overflow status bit", v[0], 1);

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule